// File: doc/BRIEF.md
# Noisy Threshold Spin Comparator

This block closes the loop of a recurrent Ising-style search engine. On every accepted cycle it takes one unsigned 8-bit receiver code for each of 64 channels. It adds a small pseudo-random signed offset to each code and clamps the sum to the code range. It then compares the clamped value with a per-channel threshold. The resulting 64-bit spin vector leaves the block one cycle later. The surrounding system feeds that vector back as the next drive pattern.

The offset is digital noise. It lets spins near their threshold flip at random instead of settling into a fixed pattern, which keeps the heuristic search moving. Its amplitude is set as a power of two, and it can be switched off entirely so the stage becomes a plain bank of comparators. Each threshold resets to the zero-light bias of 128. Thresholds and the noise settings are loaded through a single-cycle write port.

Top module: `spin_threshold_stage`

## Requirements
- R1: Synchronous active-low reset clears `out_valid` and `spin_out` to 0, sets every threshold to 128 and disables noise. After reset with noise off, a code of 128 gives 1 and a code of 127 gives 0.
- R2: `out_valid` is `in_valid` delayed by exactly one clock. When `in_valid` is 0, `spin_out` keeps its previous value.
- R3: With noise off, bit c of `spin_out` is 1 exactly when code c (bits `[8c+7:8c]` of `in_codes`) is greater than or equal to the threshold of channel c, compared as unsigned values.
- R4: A write with `cfg_addr` in 0..63 loads `cfg_wdata` as the threshold of that channel and changes no other channel. The new value applies from the next sample.
- R5: A write to address 64 sets the noise controls: bit 0 of `cfg_wdata` enables noise, and bits 3:1 give the exponent k. A value of k above 4 is stored as 4. Writes to addresses 65..127 change nothing.
- R6: While noise is disabled, the noise term is zero whatever k holds.
- R7: Each channel c has a 16-bit shift register seeded to 1 + 257*c after reset. On each accepted sample the register shifts left, and the XOR of bits 15, 13, 12 and 10 enters bit 0. With noise on, the noise for a sample is the low k+1 bits of the register value before the shift, read as a two's-complement number. That gives a range of -2^k to 2^k-1. The register advances on every sample, whether or not noise is on.
- R8: Code plus noise is clamped to 0..255 before the compare. It never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A code vector is present this cycle |
| in_codes | input | 512 | 64 unsigned 8-bit codes, channel c at bits [8c+7:8c] |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 7 | Write address: 0..63 threshold, 64 noise control |
| cfg_wdata | input | 8 | Write data |
| out_valid | output | 1 | `spin_out` was updated by the previous sample |
| spin_out | output | 64 | Spin vector, one bit per channel |

## Verification
A corrupted shift register in any channel first shows up as a wrong bit on the first sample near threshold with noise enabled. Because the bench predicts every channel's noise exactly and compares all 64 bits on every clock, a one-step slip in the register sequence, a wrong seed or a wrong sign extension is caught within a few samples. A threshold written to the wrong channel, a misdecoded control field or a wrap instead of a clamp changes a spin bit on the first sample that lands on the affected boundary.

// File: rtl/nts_pkg.sv
// Package: shared constants and helpers for the noisy threshold spin comparator.
// Assumes the per-channel noise source is a 16-bit maximal-length shift register.
package nts_pkg;
    localparam int LFSR_W = 16;

    // Distinct non-zero seed for each channel.
    function automatic logic [LFSR_W-1:0] lane_seed(input int unsigned ch);
        return LFSR_W'(32'd1 + ch * 32'd257);
    endfunction

    // One step of the x^16+x^14+x^13+x^11+1 register, shifting toward the MSB.
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction
endpackage

// File: rtl/spin_lfsr.sv
// Module: spin_lfsr
// Per-channel pseudo-random source. It holds SEED after reset and steps once per
// cycle while advance is high. Assumes SEED is non-zero.
module spin_lfsr
    import nts_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 16'h0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    output logic [LFSR_W-1:0] state
);

    // Load the seed on reset, then step once per accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= SEED;
        else if (advance)
            state <= lfsr_step(state);
    end

endmodule

// File: rtl/spin_cfg_regs.sv
// Module: spin_cfg_regs
// Write-only configuration: one threshold per channel at addresses 0..NUM_CH-1
// and a noise control word at address NUM_CH. Assumes CODE_W > KW so the
// control fields fit in one data word.
module spin_cfg_regs #(
    parameter int NUM_CH = 64,
    parameter int CODE_W = 8,
    parameter int K_MAX  = 4,
    parameter int ADDR_W = 7,
    parameter int KW     = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [ADDR_W-1:0]        cfg_addr,
    input  logic [CODE_W-1:0]        cfg_wdata,
    output logic [NUM_CH*CODE_W-1:0] thr_flat,
    output logic                     noise_en,
    output logic [KW-1:0]            noise_k
);

    localparam logic [CODE_W-1:0] THR_RESET = CODE_W'(1 << (CODE_W - 1));
    localparam logic [KW-1:0]     K_LIMIT   = KW'(K_MAX);

    logic [KW-1:0] k_field;
    assign k_field = cfg_wdata[KW:1];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_thr
        // Hold one channel threshold: bias value on reset, overwritten by an addressed write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                thr_flat[g*CODE_W +: CODE_W] <= THR_RESET;
            else if (cfg_we && cfg_addr == ADDR_W'(g))
                thr_flat[g*CODE_W +: CODE_W] <= cfg_wdata;
        end
    end

    // Hold the noise controls, clamping the exponent to K_MAX.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            noise_en <= 1'b0;
            noise_k  <= '0;
        end else if (cfg_we && cfg_addr == ADDR_W'(NUM_CH)) begin
            noise_en <= cfg_wdata[0];
            noise_k  <= (k_field > K_LIMIT) ? K_LIMIT : k_field;
        end
    end

    // R5: the stored exponent never exceeds the limit
    assert_k_clamped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        noise_k <= K_LIMIT);

    // R1: the stage leaves reset with noise off
    assert_noise_off_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> !noise_en);

endmodule

// File: rtl/spin_lane.sv
// Module: spin_lane
// One channel. It builds a signed noise term from its own shift register, adds it
// to the code, clamps the sum to the code range and registers the threshold
// compare. Assumes noise_k <= K_MAX and that LFSR_W exceeds K_MAX.
module spin_lane
    import nts_pkg::*;
#(
    parameter int              CODE_W = 8,
    parameter int              K_MAX  = 4,
    parameter int              KW     = 3,
    parameter logic [LFSR_W-1:0] SEED = 16'h0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CODE_W-1:0] code,
    input  logic [CODE_W-1:0] thr,
    input  logic              noise_en,
    input  logic [KW-1:0]     noise_k,
    output logic              spin
);

    localparam int NOISE_W = K_MAX + 2;
    localparam int SUM_W   = CODE_W + 2;

    logic [LFSR_W-1:0]  lfsr_q;
    logic [K_MAX:0]     raw;
    logic [NOISE_W-1:0] noise;
    logic [SUM_W-1:0]   sum;
    logic [CODE_W-1:0]  sat;

    spin_lfsr #(.SEED(SEED)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (in_valid),
        .state   (lfsr_q)
    );

    assign raw = lfsr_q[K_MAX:0];

    // Sign-extend the low k+1 register bits into the noise term, or force zero.
    always_comb begin
        noise = '0;
        if (noise_en) begin
            for (int b = 0; b <= K_MAX; b++)
                noise[b] = (b <= int'(noise_k)) ? raw[b] : raw[noise_k];
            noise[NOISE_W-1] = raw[noise_k];
        end
    end

    // Add the noise to the zero-extended code.
    assign sum = {2'b00, code} + {{(SUM_W-NOISE_W){noise[NOISE_W-1]}}, noise};

    // Clamp: a negative sum floors at zero, an overflow ceils at full scale.
    always_comb begin
        if (sum[SUM_W-1])
            sat = '0;
        else if (sum[SUM_W-2])
            sat = '1;
        else
            sat = sum[CODE_W-1:0];
    end

    // Register the compare on each accepted sample; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            spin <= 1'b0;
        else if (in_valid)
            spin <= (sat >= thr);
    end

    // R6: with noise disabled the noise term is exactly zero
    assert_quiet_noise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !noise_en |-> noise == '0);

    // R7: enabled noise stays within -2^k .. 2^k-1
    assert_noise_span_R7: assert property (@(posedge clk) disable iff (!rst_n)
        noise_en |-> ($signed(noise) >= -(32'sd1 <<< noise_k)) &&
                     ($signed(noise) <  (32'sd1 <<< noise_k)));

    // R7: the noise source never locks at zero
    assert_lfsr_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);

    // R3: with noise off the registered bit is the plain code compare
    assert_plain_compare_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !noise_en) |=> spin == $past(code >= thr));

    // R8: a full-scale code is never pulled below threshold by positive noise
    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && code == '1 && !noise[NOISE_W-1]) |=> spin);

endmodule

// File: rtl/spin_threshold_stage.sv
// Module: spin_threshold_stage
// Top of the noisy comparator stage: the configuration registers, NUM_CH
// channel lanes and the output valid flag. Latency is one clock from an
// accepted code vector to the spin vector.
module spin_threshold_stage
    import nts_pkg::*;
#(
    parameter  int NUM_CH = 64,
    parameter  int CODE_W = 8,
    parameter  int K_MAX  = 4,
    localparam int ADDR_W = $clog2(NUM_CH + 1),
    localparam int KW     = $clog2(K_MAX + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [NUM_CH*CODE_W-1:0] in_codes,
    input  logic                     cfg_we,
    input  logic [ADDR_W-1:0]        cfg_addr,
    input  logic [CODE_W-1:0]        cfg_wdata,
    output logic                     out_valid,
    output logic [NUM_CH-1:0]        spin_out
);

    logic [NUM_CH*CODE_W-1:0] thr_flat;
    logic                     noise_en;
    logic [KW-1:0]            noise_k;

    spin_cfg_regs #(
        .NUM_CH (NUM_CH),
        .CODE_W (CODE_W),
        .K_MAX  (K_MAX),
        .ADDR_W (ADDR_W),
        .KW     (KW)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .thr_flat  (thr_flat),
        .noise_en  (noise_en),
        .noise_k   (noise_k)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
        spin_lane #(
            .CODE_W (CODE_W),
            .K_MAX  (K_MAX),
            .KW     (KW),
            .SEED   (lane_seed(c))
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (in_valid),
            .code     (in_codes[c*CODE_W +: CODE_W]),
            .thr      (thr_flat[c*CODE_W +: CODE_W]),
            .noise_en (noise_en),
            .noise_k  (noise_k),
            .spin     (spin_out[c])
        );
    end

    // Delay the input valid by one clock to mark the spin update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else
            out_valid <= in_valid;
    end

    // R2: an accepted sample is flagged on the next clock
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: no flag appears without a sample
    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R2: the spin vector holds between samples
    assert_spin_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(spin_out));

endmodule

// File: tb/spin_threshold_stage_tb.sv
// Bench: behavioural reference model updated on every rising edge and
// compared against the outputs on every falling edge.
module spin_threshold_stage_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [511:0] in_codes = '0;
    logic         cfg_we = 1'b0;
    logic [6:0]   cfg_addr = '0;
    logic [7:0]   cfg_wdata = '0;
    logic         out_valid;
    logic [63:0]  spin_out;

    spin_threshold_stage u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_codes  (in_codes),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .out_valid (out_valid),
        .spin_out  (spin_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Reference model state
    int          m_thr [NCH];
    int          m_lfsr [NCH];
    bit          m_en;
    int          m_k;
    logic [63:0] m_spin;
    bit          m_valid;

    // Model: follows R1..R8 at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                m_thr[c]  = 128;
                m_lfsr[c] = 1 + 257 * c;
            end
            m_en = 0; m_k = 0; m_spin = '0; m_valid = 0;
        end else begin
            m_valid = in_valid;
            if (in_valid) begin
                for (int c = 0; c < NCH; c++) begin
                    int n, v, fb;
                    n = 0;
                    if (m_en) begin
                        n = m_lfsr[c] % (1 << (m_k + 1));
                        if (n >= (1 << m_k)) n = n - (1 << (m_k + 1));
                    end
                    v = int'(in_codes[c*8 +: 8]) + n;
                    if (v < 0) v = 0;
                    if (v > 255) v = 255;
                    m_spin[c] = (v >= m_thr[c]);
                    fb = ((m_lfsr[c] >> 15) ^ (m_lfsr[c] >> 13) ^
                          (m_lfsr[c] >> 12) ^ (m_lfsr[c] >> 10)) & 1;
                    m_lfsr[c] = ((m_lfsr[c] << 1) & 16'hFFFF) | fb;
                end
            end
            if (cfg_we) begin
                if (cfg_addr < 7'd64)
                    m_thr[cfg_addr] = int'(cfg_wdata);
                else if (cfg_addr == 7'd64) begin
                    m_en = cfg_wdata[0];
                    m_k  = (int'(cfg_wdata[3:1]) > 4) ? 4 : int'(cfg_wdata[3:1]);
                end
            end
        end
    end

    // Compare outputs with the model on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (out_valid !== m_valid) begin
                failures++;
                $display("FAIL R2 out_valid actual=%0b expected=%0b", out_valid, m_valid);
            end
            checks++;
            if (spin_out !== m_spin) begin
                failures++;
                $display("FAIL %s spin_out actual=%h expected=%h", cur_req, spin_out, m_spin);
            end
        end
    end

    task automatic set_codes_all(input int val);
        for (int c = 0; c < NCH; c++) in_codes[c*8 +: 8] = 8'(val);
    endtask

    // One clock of stimulus, applied right after a falling edge
    task automatic tick(input bit v, input bit we, input int addr, input int data);
        in_valid  = v;
        cfg_we    = we;
        cfg_addr  = 7'(addr);
        cfg_wdata = 8'(data);
        @(negedge clk);
        in_valid = 1'b0;
        cfg_we   = 1'b0;
    endtask

    function automatic int thr_of(input int c);
        return (c * 4 + 1) % 256;
    endfunction

    initial begin
        // R1: reset, then sample at the default threshold
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        set_codes_all(128);
        tick(1, 0, 0, 0);
        set_codes_all(127);
        tick(1, 0, 0, 0);
        tick(0, 0, 0, 0);

        // R2: idle cycles hold the vector, then a sample lifts it again
        cur_req = "R2";
        set_codes_all(200);
        repeat (3) tick(0, 0, 0, 0);
        tick(1, 0, 0, 0);
        repeat (2) tick(0, 0, 0, 0);

        // R4: load distinct thresholds, one channel at a time
        cur_req = "R4";
        for (int c = 0; c < NCH; c++) tick(0, 1, c, thr_of(c));
        tick(0, 1, 5, 0);
        tick(0, 1, 6, 255);
        for (int c = 0; c < NCH; c++) in_codes[c*8 +: 8] = 8'(thr_of(c));
        tick(1, 0, 0, 0);
        tick(0, 0, 0, 0);

        // R3: codes on, just below and far from each threshold, noise off
        cur_req = "R3";
        for (int c = 0; c < NCH; c++) in_codes[c*8 +: 8] = 8'(thr_of(c) - 1);
        tick(1, 0, 0, 0);
        for (int j = 0; j < 40; j++) begin
            for (int c = 0; c < NCH; c++) in_codes[c*8 +: 8] = 8'(c * 29 + j * 53 + (c ^ j));
            tick(1, 0, 0, 0);
        end

        // R5: unused addresses ignored; out-of-range exponent clamped
        cur_req = "R5";
        tick(0, 1, 65, 8'hFF);
        tick(0, 1, 127, 8'h00);
        for (int c = 0; c < NCH; c++) in_codes[c*8 +: 8] = 8'(thr_of(c));
        tick(1, 0, 0, 0);
        tick(0, 1, 64, 8'h0F);
        for (int j = 0; j < 30; j++) begin
            for (int c = 0; c < NCH; c++) in_codes[c*8 +: 8] = 8'(thr_of(c) + (j % 5) - 2);
            tick(1, 0, 0, 0);
        end

        // R6: noise disabled while k stays at its maximum
        cur_req = "R6";
        tick(0, 1, 64, 8'h08);
        for (int j = 0; j < 20; j++) begin
            for (int c = 0; c < NCH; c++) in_codes[c*8 +: 8] = 8'(thr_of(c) + (j % 3) - 1);
            tick(1, 0, 0, 0);
        end

        // R7: every exponent, near-threshold codes, with gaps between samples
        cur_req = "R7";
        for (int k = 0; k <= 4; k++) begin
            tick(0, 1, 64, (k << 1) | 1);
            for (int j = 0; j < 60; j++) begin
                for (int c = 0; c < NCH; c++)
                    in_codes[c*8 +: 8] = 8'(thr_of(c) + ((c + j) % 7) - 3);
                tick((j % 4) != 3, 0, 0, 0);
            end
        end

        // R8: clamping at both ends of the code range
        cur_req = "R8";
        for (int c = 0; c < NCH; c++) tick(0, 1, c, (c < 32) ? 255 : 1);
        tick(0, 1, 64, 8'h09);
        for (int j = 0; j < 40; j++) begin
            for (int c = 0; c < NCH; c++)
                in_codes[c*8 +: 8] = (c < 32) ? 8'(250 + (j % 6)) : 8'(j % 3);
            tick(1, 0, 0, 0);
        end
        tick(0, 0, 0, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule